// File: doc/BRIEF.md
# I2C Target Register Port

This block is an I2C target that lets an external bus controller read and write a file of sixteen 8-bit registers. It oversamples SCL and SDA on the system clock and drives SDA as an open-drain output. It answers one 7-bit device address. The upper six bits of that address are fixed, and the lowest bit follows a strap input. There is no chip-select input, so address matching alone selects the device.

A write transfer begins with a pointer byte. The pointer byte holds a register index and a flag that makes the index step forward after each data byte. The data bytes that follow go into the register file. A read transfer has no pointer byte. It returns data from wherever the pointer was left, and it keeps returning bytes until the controller answers a byte with a not-acknowledge. Every register is visible at all times on a flat parallel output bus.

Top module: `i2c_reg_port`

## Requirements
- R1: After reset every register is 0x00, the register index is 0 and the increment flag is 0.
- R2: The target acknowledges by pulling SDA low during the ninth clock of the first byte when that byte's upper seven bits equal 0b001000 followed by the level on `addr_strap_i`.
- R3: When the address does not match, no acknowledge is given and no later byte is acknowledged or stored until the next START.
- R4: Bit 0 of the address byte gives the direction: 0 selects a write transfer and 1 selects a read transfer.
- R5: In a write, the first byte after the address is the pointer. Bit 7 is the increment flag and bits 3:0 are the register index. Bits 6:4 have no effect. The pointer byte and every data byte are acknowledged.
- R6: When the increment flag is 0, every data byte of the transfer is stored into the same register.
- R7: When the increment flag is 1, the index advances by one after each data byte, wrapping from 15 to 0.
- R8: A read shifts out the register at the current index, MSB first, starting right after the address acknowledge. It uses the pointer left by earlier transfers, and the index advances after each byte when the flag is 1.
- R9: When the controller answers a read byte with a not-acknowledge, the target releases SDA and drives nothing more until the next START.
- R10: A repeated START or a STOP at any point returns the target to address wait. A partly received byte is discarded.
- R11: Register k appears on `regs_o[8k+7:8k]`, and only one register changes per stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired line) |
| addr_strap_i | input | 1 | Level that sets the device address LSB |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 128 | All sixteen registers, register k in bits 8k+7:8k |

## Verification
The assertions assume a well-formed bus. The controller changes SDA only while SCL is low, except when it forms START and STOP. Every SCL level lasts several system clocks, longer than the input synchronizer delay. The controller never makes a START or STOP while the target is holding SDA low. The bench drives the bus through tasks that hold each SCL phase for eight clocks. Those tasks move SDA only in the middle of a low phase and release it before any acknowledge or read bit, so random transfers stay inside these assumptions.

// File: rtl/i2c_reg_port.sv
module i2c_reg_port #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_HI      = 6'b001000,
  parameter int         IDX_W       = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       addr_strap_i,
  output logic                       sda_oe_o,
  output logic [(8<<IDX_W)-1:0]      regs_o
);
  localparam int NREG = 1 << IDX_W;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2, S_PTR = 4'd3, S_PACK = 4'd4,
    S_WDAT = 4'd5, S_WACK = 4'd6, S_RDAT = 4'd7, S_RACK = 4'd8
  } state_t;

  logic [SYNC_STAGES:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_s, sda_q;
  logic scl_rise, scl_fall, start_c, stop_c;

  state_t           st;
  logic [3:0]       bitcnt;
  logic [7:0]       sh, osh;
  logic [IDX_W-1:0] idx;
  logic             incr, rw, mnack;
  logic [7:0]       regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
    end

  assign scl_s    = scl_p[SYNC_STAGES-1];
  assign scl_q    = scl_p[SYNC_STAGES];
  assign sda_s    = sda_p[SYNC_STAGES-1];
  assign sda_q    = sda_p[SYNC_STAGES];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      osh      <= '0;
      idx      <= '0;
      incr     <= 1'b0;
      rw       <= 1'b0;
      mnack    <= 1'b1;
      sda_oe_o <= 1'b0;
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (start_c) begin
      st       <= S_ADDR;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      st       <= S_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      if (scl_rise)
        case (st)
          S_ADDR, S_PTR, S_WDAT:
            if (bitcnt < 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
          S_RDAT: bitcnt <= bitcnt + 4'd1;
          S_RACK: mnack <= sda_s;
          default: ;
        endcase
      if (scl_fall)
        case (st)
          S_ADDR:
            if (bitcnt == 4'd8) begin
              if (sh[7:1] == {DEV_HI, addr_strap_i}) begin
                st       <= S_AACK;
                sda_oe_o <= 1'b1;
                rw       <= sh[0];
              end else
                st <= S_IDLE;
            end
          S_AACK: begin
            bitcnt <= '0;
            if (rw) begin
              st       <= S_RDAT;
              osh      <= regs[idx];
              sda_oe_o <= ~regs[idx][7];
            end else begin
              st       <= S_PTR;
              sda_oe_o <= 1'b0;
            end
          end
          S_PTR:
            if (bitcnt == 4'd8) begin
              incr     <= sh[7];
              idx      <= sh[IDX_W-1:0];
              st       <= S_PACK;
              sda_oe_o <= 1'b1;
            end
          S_PACK, S_WACK: begin
            st       <= S_WDAT;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
          end
          S_WDAT:
            if (bitcnt == 4'd8) begin
              regs[idx] <= sh;
              if (incr) idx <= idx + 1'b1;
              st       <= S_WACK;
              sda_oe_o <= 1'b1;
            end
          S_RDAT:
            if (bitcnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              st       <= S_RACK;
              if (incr) idx <= idx + 1'b1;
            end else begin
              osh      <= {osh[6:0], 1'b0};
              sda_oe_o <= ~osh[6];
            end
          S_RACK:
            if (mnack)
              st <= S_IDLE;
            else begin
              st       <= S_RDAT;
              bitcnt   <= '0;
              osh      <= regs[idx];
              sda_oe_o <= ~regs[idx][7];
            end
          default: ;
        endcase
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk #(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_s,
  input logic [3:0]        st,
  input logic [NREG*8-1:0] regs_o
);
  localparam logic [3:0] C_IDLE = 4'd0, C_ADDR = 4'd1, C_AACK = 4'd2,
                         C_PACK = 4'd4, C_WDAT = 4'd5, C_WACK = 4'd6, C_RDAT = 4'd7;

  logic [NREG*8-1:0] prev;
  logic [NREG-1:0]   chg;

  always_ff @(posedge clk) prev <= regs_o;

  always_comb
    for (int k = 0; k < NREG; k++) chg[k] = (regs_o[k*8 +: 8] != prev[k*8 +: 8]);

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (regs_o == '0));

  p_drive_on_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE) |-> !sda_oe);

  p_drive_states_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == C_AACK || st == C_PACK || st == C_WACK || st == C_RDAT));

  p_store_only_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_WDAT) |=> $stable(regs_o));

  p_addr_wait_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ADDR) |-> !sda_oe);

  p_one_reg_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));
endmodule

bind i2c_reg_port i2c_reg_port_chk #(.NREG(1 << IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s), .st(st), .regs_o(regs_o)
);

// File: tb/i2c_reg_port_bench.sv
module i2c_reg_port_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe;
  logic [127:0] regs_o;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  logic [7:0] mreg [16];
  int mptr = 0;
  bit mincr = 1'b0;
  logic [7:0] wbuf [8];

  always #5 clk = ~clk;

  i2c_reg_port u_i2c_reg_port (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] dev();
    return {6'b001000, strap};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    ack = ~sda_line;
    scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(Q); scl_m = 1'b1; w(Q); b = {b[6:0], sda_line}; scl_m = 1'b0;
    end
    w(Q); sda_m = nack; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(4); sda_m = 1'b1;
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < 16; k++)
      chk(regs_o[k*8 +: 8] == mreg[k], req, regs_o[k*8 +: 8], mreg[k]);
  endtask

  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] ptr, input int n, input bit exp_ack);
    logic ack;
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk(ack == exp_ack, exp_ack ? "R2 R4 address ack" : "R3 no address ack", ack, exp_ack);
    send_byte(ptr, ack);
    chk(ack == exp_ack, exp_ack ? "R5 pointer ack" : "R3 pointer ignored", ack, exp_ack);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      chk(ack == exp_ack, exp_ack ? "R5 data ack" : "R3 data ignored", ack, exp_ack);
    end
    bus_stop();
    if (exp_ack) begin
      mincr = ptr[7];
      mptr  = int'(ptr[3:0]);
      for (int k = 0; k < n; k++) begin
        mreg[mptr] = wbuf[k];
        if (mincr) mptr = (mptr + 1) % 16;
      end
    end
  endtask

  task automatic rd_bytes(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, b);
      chk(b == mreg[mptr], req, b, mreg[mptr]);
      if (mincr) mptr = (mptr + 1) % 16;
    end
  endtask

  task automatic rd_xfer(input int n, input string req);
    logic ack;
    bus_start();
    send_byte({dev(), 1'b1}, ack);
    chk(ack, "R2 R4 read address ack", ack, 1'b1);
    rd_bytes(n, req);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    bit idle_ok;
    void'($urandom(32'd4242));
    for (int k = 0; k < 16; k++) mreg[k] = 8'h00;
    w(6);
    chk(regs_o == '0, "R1 reset registers", regs_o[31:0], 32'h0);
    chk(sda_oe == 1'b0, "R1 reset SDA released", sda_oe, 1'b0);
    rst_n = 1'b1;
    w(4);

    rd_xfer(2, "R1 R8 read after reset from index 0");

    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    wr_xfer(dev(), 8'h8E, 3, 1'b1);
    check_regs("R7 R11 burst write wraps 15 to 0");

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_xfer(dev(), 8'h05, 3, 1'b1);
    check_regs("R6 fixed index write");

    wbuf[0] = 8'h44;
    wr_xfer(dev(), 8'hF3, 1, 1'b1);
    check_regs("R5 reserved pointer bits ignored");

    rd_xfer(3, "R8 burst read from pointer left by write");

    wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
    wr_xfer(7'h50, 8'h81, 2, 1'b0);
    check_regs("R3 foreign address stores nothing");

    wr_xfer({6'b001000, 1'b1}, 8'h81, 2, 1'b0);
    check_regs("R2 strap mismatch stores nothing");
    strap = 1'b1;
    w(2);
    wbuf[0] = 8'h6C;
    wr_xfer(dev(), 8'h89, 1, 1'b1);
    check_regs("R2 strap high address accepted");

    bus_start();
    send_byte({dev(), 1'b0}, ack);
    send_byte(8'h82, ack);
    send_byte(8'h5A, ack);
    chk(ack, "R5 data ack before repeated start", ack, 1'b1);
    mincr = 1'b1; mptr = 2; mreg[2] = 8'h5A; mptr = 3;
    send_bits(8'hF0, 4);
    bus_start();
    send_byte({dev(), 1'b1}, ack);
    chk(ack, "R10 repeated start address ack", ack, 1'b1);
    rd_bytes(1, "R10 read after repeated start");
    check_regs("R10 partial byte discarded");

    idle_ok = 1'b1;
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      w(Q); scl_m = 1'b1; w(Q);
      if (!sda_line || sda_oe) idle_ok = 1'b0;
      scl_m = 1'b0;
    end
    chk(idle_ok, "R9 SDA released after not-acknowledge", idle_ok, 1'b1);
    bus_stop();

    bus_start();
    send_byte({dev(), 1'b0}, ack);
    send_byte(8'h80, ack);
    send_bits(8'hFF, 3);
    bus_stop();
    mincr = 1'b1; mptr = 0;
    check_regs("R10 stop mid byte discards data");

    for (int t = 0; t < 30; t++) begin
      if ($urandom_range(1, 0) == 1) begin
        int n;
        logic [7:0] p;
        n = $urandom_range(4, 1);
        p = 8'($urandom);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        wr_xfer(dev(), p, n, 1'b1);
        check_regs(p[7] ? "R7 random burst write" : "R6 random fixed write");
      end else begin
        rd_xfer($urandom_range(4, 1), "R8 random read");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule